// File: doc/BRIEF.md
# Bus-Attached 16-bit Multiply-Accumulate Unit

This block is a multiplier that a small processor reaches purely through word-wide register writes and reads on its data bus. The processor places the first factor at one of four addresses; which of the four it uses decides whether the next computation is an unsigned product, a signed product, an unsigned running sum of products or a signed running sum of products. Storing the second factor at its own address starts the work. Two clock edges later the 32-bit outcome can be read back as a low word and a high word, with a third register giving either the sign extension of a product or the carry that fell out of the top of the accumulator.

In the accumulating modes the two result words act as one 32-bit accumulator, so a long dot product is a sequence of factor writes with no reads in between. Software seeds or clears that accumulator by writing the result words directly. The first factor and the selected mode stay in place, so a string of second-factor writes reuses them. A busy output is high while a computation is in flight.

Top module: `mulacc_unit`

## Requirements
- R1: After reset the low result, high result and extension registers read 0, the busy output is 0, and both factor registers read 0.
- R2: Address map (word addresses): a write to 0, 1, 2 or 3 loads the first factor and selects unsigned multiply, signed multiply, unsigned accumulate or signed accumulate respectively; a write to 4 loads the second factor and launches the selected operation; 5 is the low result word, 6 the high result word, 7 the extension register. Reads of 0 to 3 return the first factor and a read of 4 returns the second factor.
- R3: The result and extension registers take the new value on the second rising clock edge after the edge that accepts the second-factor write; a read after only the first of those edges returns the previous result. Busy is 1 after the accepting edge and back to 0 after the second edge when nothing else was launched.
- R4: Unsigned multiply replaces the 32-bit result with the unsigned product and sets the extension register to 0.
- R5: Signed multiply replaces the result with the two's complement product and sets the extension register to 0xFFFF when that product is negative, else 0.
- R6: Unsigned accumulate adds the unsigned product to the 32-bit result; the extension register then holds the carry out of bit 31 (0 or 1).
- R7: Signed accumulate adds the sign-extended 32-bit product to the result as a 32-bit pattern; the extension register holds the carry out of bit 31 of that addition.
- R8: Writes to addresses 5 and 6 load the low and high result words, so the accumulator can be preloaded or cleared.
- R9: The first factor and mode are retained; each further second-factor write repeats the operation with the stored first factor.
- R10: Second-factor writes on consecutive clock cycles are each applied in order; an accumulating run folds every product into the sum.
- R11: Writes to the extension register are ignored, and reads of addresses 8 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Bus write strobe, one word per cycle |
| addr | input | 4 | Word address of the register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the addressed register, combinational |
| busy | output | 1 | High while a launched operation has not yet committed |

## Verification
The bench goes after the latency edge by reading the result one cycle too early, which exposes a design that commits in one cycle or three. Signed products of mixed-sign factors and an all-ones unsigned square catch a design that extends operands the wrong way or truncates the product. Preloading the accumulator near its top and then accumulating checks that the carry lands in the extension register rather than wrapping silently, and a pair of back-to-back second-factor writes catches a design that loses the first product or accumulates against a stale sum. A write to the extension register and a read of an unmapped address confirm that neither disturbs or leaks state.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  // bit 0: signed operands, bit 1: accumulate into result
  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_UMAC = 2'd2,
    MODE_SMAC = 2'd3
  } mode_e;

  localparam logic [ADDR_W-1:0] ADR_OPB = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_LO  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_HI  = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_EXT = 4'd7;

  typedef struct packed {
    logic  loadA;
    logic  launch;
    logic  multiply;
    logic  finish;
    logic  wrLo;
    logic  wrHi;
    mode_e mulMode;
    mode_e finishMode;
  } ctrl_s;
endpackage

// File: rtl/mulacc_ctrl.sv
module mulacc_ctrl
  import mulacc_pkg::*;
#(
  parameter int ADDR_WIDTH = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_WIDTH-1:0] addr,
  output ctrl_s                 strobes,
  output logic                  busy
);
  logic  isOpA;
  mode_e curMode;
  logic  stg1Valid, stg2Valid;
  mode_e stg1Mode, stg2Mode;

  assign isOpA = wrEn && (addr < ADDR_WIDTH'(4));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode   <= MODE_UMUL;
      stg1Valid <= 1'b0;
      stg2Valid <= 1'b0;
      stg1Mode  <= MODE_UMUL;
      stg2Mode  <= MODE_UMUL;
    end else begin
      if (isOpA) curMode <= mode_e'(addr[1:0]);
      stg1Valid <= strobes.launch;
      stg1Mode  <= curMode;
      stg2Valid <= stg1Valid;
      stg2Mode  <= stg1Mode;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.loadA      = isOpA;
    strobes.launch     = wrEn && (addr == ADR_OPB);
    strobes.wrLo       = wrEn && (addr == ADR_LO);
    strobes.wrHi       = wrEn && (addr == ADR_HI);
    strobes.multiply   = stg1Valid;
    strobes.mulMode    = stg1Mode;
    strobes.finish     = stg2Valid;
    strobes.finishMode = stg2Mode;
  end

  assign busy = stg1Valid || stg2Valid;

  // R3: a launch commits exactly two edges later
  a_r3_commit_two_later: assert property (@(posedge clk) disable iff (!rstN)
    strobes.launch |-> ##2 strobes.finish);
  // R3: busy is raised on the edge after a launch
  a_r3_busy_after_launch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.launch |=> busy);
  // R2: at most one register targeted per write
  a_r2_decode_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadA, strobes.launch, strobes.wrLo, strobes.wrHi}));
endmodule

// File: rtl/mulacc_dpath.sv
module mulacc_dpath
  import mulacc_pkg::*;
#(
  parameter int DATA_WIDTH = DATA_W,
  parameter int ADDR_WIDTH = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_s                 strobes,
  input  logic [DATA_WIDTH-1:0] wrData,
  input  logic [ADDR_WIDTH-1:0] addr,
  output logic [DATA_WIDTH-1:0] rdData
);
  localparam int PROD_W = 2 * DATA_WIDTH;
  localparam int EXT_W  = DATA_WIDTH + 1;

  logic [DATA_WIDTH-1:0] opA, opB, aLat;
  logic [PROD_W-1:0]     prodReg, acc;
  logic [DATA_WIDTH-1:0] ext;
  logic signed [EXT_W-1:0]   extA, extB;
  logic signed [2*EXT_W-1:0] fullProd;
  logic [PROD_W:0]       sumWide;
  logic                  mulSigned;

  assign mulSigned = strobes.mulMode[0];
  assign extA      = $signed({mulSigned & aLat[DATA_WIDTH-1], aLat});
  assign extB      = $signed({mulSigned & opB[DATA_WIDTH-1], opB});
  assign fullProd  = extA * extB;
  assign sumWide   = {1'b0, acc} + {1'b0, prodReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA     <= '0;
      opB     <= '0;
      aLat    <= '0;
      prodReg <= '0;
    end else begin
      if (strobes.loadA) opA <= wrData;
      if (strobes.launch) begin
        opB  <= wrData;
        aLat <= opA;
      end
      if (strobes.multiply) prodReg <= fullProd[PROD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
      ext <= '0;
    end else if (strobes.finish) begin
      if (strobes.finishMode[1]) begin
        acc <= sumWide[PROD_W-1:0];
        ext <= DATA_WIDTH'(sumWide[PROD_W]);
      end else begin
        acc <= prodReg;
        ext <= (strobes.finishMode[0] && prodReg[PROD_W-1]) ? '1 : '0;
      end
    end else begin
      if (strobes.wrLo) acc[DATA_WIDTH-1:0]      <= wrData;
      if (strobes.wrHi) acc[PROD_W-1:DATA_WIDTH] <= wrData;
    end
  end

  always_comb begin
    if (addr < ADDR_WIDTH'(4))   rdData = opA;
    else if (addr == ADR_OPB)    rdData = opB;
    else if (addr == ADR_LO)     rdData = acc[DATA_WIDTH-1:0];
    else if (addr == ADR_HI)     rdData = acc[PROD_W-1:DATA_WIDTH];
    else if (addr == ADR_EXT)    rdData = ext;
    else                         rdData = '0;
  end

  // R4: unsigned multiply leaves a zero extension
  a_r4_umul_ext_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && strobes.finishMode == MODE_UMUL) |=> ext == '0);
  // R5: signed multiply extension mirrors the product sign
  a_r5_smul_ext_sign: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && strobes.finishMode == MODE_SMUL)
      |=> ext == {DATA_WIDTH{acc[PROD_W-1]}});
  // R6/R7: accumulate extension is a single carry bit
  a_r6_carry_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && strobes.finishMode[1]) |=> ext[DATA_WIDTH-1:1] == '0);
  // R11: extension changes only on a commit
  a_r11_ext_readonly: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> $stable(ext));
  // R8: preload of the low word takes effect
  a_r8_preload_lo: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLo && !strobes.finish) |=> acc[DATA_WIDTH-1:0] == $past(wrData));
endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit
  import mulacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);
  ctrl_s strobes;

  mulacc_ctrl #(.ADDR_WIDTH(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .strobes(strobes), .busy(busy)
  );

  mulacc_dpath #(.DATA_WIDTH(DATA_W), .ADDR_WIDTH(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .addr(addr), .rdData(rdData)
  );
endmodule

// File: tb/mulacc_unit_tb.sv
module mulacc_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic        busy;
  int checks = 0;
  int errors = 0;

  mulacc_unit dut_i (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
                     .wrData(wrData), .rdData(rdData), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic checkReg(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, {16'd0, v}, {16'd0, exp});
  endtask

  task automatic checkRes(input string req, input logic [31:0] expRes, input logic [15:0] expExt);
    logic [15:0] lo, hi, ex;
    rd(4'd5, lo); rd(4'd6, hi); rd(4'd7, ex);
    check(req, {hi, lo}, expRes);
    check(req, {16'd0, ex}, {16'd0, expExt});
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic runOp(input logic [3:0] modeAdr, input logic [15:0] a, input logic [15:0] b);
    wr(modeAdr, a);
    wr(4'd4, b);
    waitEdges(2);
  endtask

  task automatic preload(input logic [31:0] v);
    wr(4'd5, v[15:0]);
    wr(4'd6, v[31:16]);
  endtask

  task automatic t_reset;
    checkRes("R1 result after reset", 32'd0, 16'd0);
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    checkReg("R1 opA after reset", 4'd0, 16'd0);
    checkReg("R1 opB after reset", 4'd4, 16'd0);
  endtask

  task automatic t_latency;
    preload(32'h1111_2222);
    wr(4'd0, 16'd7);
    wr(4'd4, 16'd9);
    check("R3 busy after launch", {31'd0, busy}, 32'd1);
    waitEdges(1);
    check("R3 busy mid flight", {31'd0, busy}, 32'd1);
    checkRes("R3 stale after one edge", 32'h1111_2222, 16'd0);
    waitEdges(1);
    check("R3 busy cleared", {31'd0, busy}, 32'd0);
    checkRes("R3 R4 result after two edges", 32'd63, 16'd0);
  endtask

  task automatic t_umul;
    runOp(4'd0, 16'hFFFF, 16'hFFFF);
    checkRes("R4 unsigned full square", 32'hFFFE_0001, 16'd0);
    checkReg("R2 opA readback", 4'd2, 16'hFFFF);
    checkReg("R2 opB readback", 4'd4, 16'hFFFF);
  endtask

  task automatic t_smul;
    runOp(4'd1, 16'hFFFF, 16'h0002);
    checkRes("R5 signed negative product", 32'hFFFF_FFFE, 16'hFFFF);
    runOp(4'd1, 16'h8000, 16'h8000);
    checkRes("R5 signed min squared", 32'h4000_0000, 16'd0);
    runOp(4'd1, 16'h0003, 16'hFFFC);
    checkRes("R5 signed mixed", 32'hFFFF_FFF4, 16'hFFFF);
  endtask

  task automatic t_umac;
    preload(32'hFFFF_FFFF);
    runOp(4'd2, 16'd1, 16'd1);
    checkRes("R6 R8 unsigned accumulate carry", 32'd0, 16'd1);
    wr(4'd4, 16'd5);
    waitEdges(2);
    checkRes("R6 R9 reuse factor no carry", 32'd5, 16'd0);
  endtask

  task automatic t_smac;
    preload(32'h0000_0010);
    runOp(4'd3, 16'hFFFD, 16'h0002);
    checkRes("R7 signed accumulate", 32'h0000_000A, 16'd1);
    preload(32'h0000_0000);
    runOp(4'd3, 16'hFFFF, 16'h0001);
    checkRes("R7 signed accumulate from zero", 32'hFFFF_FFFF, 16'd0);
  endtask

  task automatic t_reuse;
    runOp(4'd0, 16'd100, 16'd3);
    wr(4'd4, 16'd4);
    waitEdges(2);
    checkRes("R9 reused factor and mode", 32'd400, 16'd0);
  endtask

  task automatic t_backToBack;
    preload(32'd0);
    wr(4'd2, 16'd2);
    wr(4'd4, 16'd3);
    wr(4'd4, 16'd5);
    waitEdges(2);
    checkRes("R10 consecutive accumulates", 32'd16, 16'd0);
    runOp(4'd0, 16'd6, 16'd6);
    checkRes("R4 multiply overwrites sum", 32'd36, 16'd0);
  endtask

  task automatic t_ignored;
    runOp(4'd1, 16'hFFFF, 16'h0001);
    wr(4'd7, 16'h1234);
    checkReg("R11 ext write ignored", 4'd7, 16'hFFFF);
    checkReg("R11 unmapped read zero", 4'd9, 16'd0);
    checkReg("R11 unmapped read zero high", 4'd15, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    t_reset();
    rstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_latency();
    t_umul();
    t_smul();
    t_umac();
    t_smac();
    t_reuse();
    t_backToBack();
    t_ignored();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule